// File: doc/BRIEF.md
# Banked Upper-Memory Mapper

This block sits between an 8-bit processor bus and a flat 64 KiB physical RAM. It also holds a 12 KiB read-only image that covers the upper window $D000–$FFFF. A group of sixteen control addresses at $C080–$C08F sets three mode bits:

- write protection for the upper RAM;
- the source for reads from the upper window, either the read-only image or RAM;
- which of two 4 KiB RAM banks answers in the $D000–$DFFF sub-window.

Every bus cycle is steered by the current mode. Upper reads come from the image or from the RAM. Upper writes are passed to the RAM or dropped. Addresses in bank 1 are rewritten to the physical page $C000–$CFFF.

The mapper is combinational on the bus path. Only the mode is registered. It changes on the clock edge of a control access and governs the bus from the next cycle on. The read-only image is generated inside the block, so nothing outside has to be preloaded.

Top module: `lcard_mapper`

## Requirements
- R1: After reset, upper reads return the read-only image, upper RAM accepts writes, and $D000–$DFFF maps to bank 2.
- R2: With bank 2 selected, $D000–$DFFF accesses go to physical $D000–$DFFF. With bank 1 selected, they go to physical $C000–$CFFF with the same low 12 address bits. $E000–$FFFF always maps to the same physical address.
- R3: While upper reads come from the image, an upper write still drives a RAM write. Later reads of that address still return the image byte.
- R4: While write protection is on, no write to $D000–$FFFF produces a RAM write strobe, and the stored bytes stay unchanged.
- R5: In a control access, address bit 3 set selects bank 1 and bit 3 clear selects bank 2. Address bit 2 has no effect.
- R6: In a control access, address bits [1:0] set the mode as follows: 00 = RAM reads with writes protected; 01 = image reads with writes allowed; 10 = image reads with writes protected; 11 = RAM reads with writes allowed.
- R7: A read strobe or a write strobe at $C080–$C08F updates the mode. That access returns 0x00 on the read data and asserts no RAM write.
- R8: Addresses below $D000 outside $C080–$C08F pass to RAM unchanged and are never write protected.
- R9: A mode change applies to the bus cycle right after the control access. The control access itself is decoded under the old mode.
- R10: With RAM reads selected, an upper read returns the byte stored in the currently selected bank. Changing the bank exposes the other bank's earlier contents.
- R11: The image byte at window offset k = address − $D000 is k[7:0] XOR k[13:8] XOR 0x5A, with k[13:8] zero-extended to 8 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | Bus address |
| cpu_wdata | input | 8 | Bus write data |
| cpu_rd | input | 1 | Bus read strobe |
| cpu_wr | input | 1 | Bus write strobe |
| cpu_rdata | output | 8 | Bus read data |
| ram_addr | output | 16 | Physical RAM address after remapping |
| ram_wdata | output | 8 | Physical RAM write data |
| ram_we | output | 1 | Physical RAM write strobe |
| ram_rdata | input | 8 | Physical RAM read data |

## Verification
Two functions can fall in the same cycle: a mode update and the steering of the upper access that comes right after it. In the bench, a control access is followed with no idle cycle by an upper read or write.

Each such access is judged against the mode the control address encodes. This covers the bank remap of a write, the read data of a read, and the write strobe under protection.

The control access is also checked on its own cycle, under the old mode. It must return zero and must not write RAM.

// File: rtl/lcard_pkg.sv
package lcard_pkg;

    localparam int LC_AW = 16;
    localparam int LC_DW = 8;
    localparam int LC_ROM_AW = 14;

    typedef struct packed {
        logic wprot;
        logic rd_rom;
        logic bank1;
    } lc_mode_t;

    localparam lc_mode_t LC_MODE_RESET = '{wprot: 1'b0, rd_rom: 1'b1, bank1: 1'b0};

    typedef enum logic [1:0] {
        RG_LOWER  = 2'd0,
        RG_SWITCH = 2'd1,
        RG_BANKED = 2'd2,
        RG_FIXED  = 2'd3
    } lc_region_e;

    function automatic lc_mode_t lc_decode(input logic bank_bit, input logic [1:0] code);
        lc_mode_t m;
        m.bank1 = bank_bit;
        case (code)
            2'b00:   begin m.rd_rom = 1'b0; m.wprot = 1'b1; end
            2'b01:   begin m.rd_rom = 1'b1; m.wprot = 1'b0; end
            2'b10:   begin m.rd_rom = 1'b1; m.wprot = 1'b1; end
            default: begin m.rd_rom = 1'b0; m.wprot = 1'b0; end
        endcase
        return m;
    endfunction

    function automatic logic [LC_DW-1:0] lc_rom_byte(input logic [LC_ROM_AW-1:0] off);
        return off[7:0] ^ {2'b00, off[13:8]} ^ 8'h5A;
    endfunction

endpackage

// File: rtl/lcard_region_dec.sv
module lcard_region_dec
    import lcard_pkg::*;
#(
    parameter int AW = LC_AW,
    parameter logic [AW-5:0] SW_PAGE = 12'hC08,
    parameter logic [3:0] BANK_PAGE = 4'hD
) (
    input  logic [AW-1:0] addr,
    output lc_region_e    region
);
    localparam int TOP = AW - 1;
    localparam int PG_LO = AW - 4;

    always_comb begin
        if (addr[TOP:4] == SW_PAGE)
            region = RG_SWITCH;
        else if (addr[TOP:PG_LO] == BANK_PAGE)
            region = RG_BANKED;
        else if (addr[TOP:PG_LO] > BANK_PAGE)
            region = RG_FIXED;
        else
            region = RG_LOWER;
    end
endmodule

// File: rtl/lcard_mode_reg.sv
module lcard_mode_reg
    import lcard_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       hit,
    input  logic       sel_bank,
    input  logic [1:0] sel_code,
    output lc_mode_t   mode
);
    always_ff @(posedge clk) begin
        if (rst)
            mode <= LC_MODE_RESET;
        else if (hit)
            mode <= lc_decode(sel_bank, sel_code);
    end

    // R9
    mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !hit |=> $stable(mode));

    // R5
    bank_take_chk: assert property (@(posedge clk) disable iff (rst)
        hit |=> (mode.bank1 == $past(sel_bank)));
endmodule

// File: rtl/lcard_rom.sv
module lcard_rom
    import lcard_pkg::*;
#(
    parameter int RAW = LC_ROM_AW,
    parameter int DW = LC_DW
) (
    input  logic [RAW-1:0] off,
    output logic [DW-1:0]  data
);
    always_comb data = lc_rom_byte(off);
endmodule

// File: rtl/lcard_addr_map.sv
module lcard_addr_map
    import lcard_pkg::*;
#(
    parameter int AW = LC_AW,
    parameter int DW = LC_DW,
    parameter logic [3:0] BANK1_PAGE = 4'hC
) (
    input  logic          clk,
    input  logic          rst,
    input  lc_region_e    region,
    input  lc_mode_t      mode,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          rd,
    input  logic          wr,
    input  logic [DW-1:0] rom_data,
    input  logic [DW-1:0] ram_rdata,
    output logic [AW-1:0] ram_addr,
    output logic [DW-1:0] ram_wdata,
    output logic          ram_we,
    output logic [DW-1:0] rdata
);
    localparam int PG_LO = AW - 4;
    logic upper;

    always_comb begin
        upper     = (region == RG_BANKED) || (region == RG_FIXED);
        ram_wdata = wdata;
        ram_addr  = addr;
        if (region == RG_BANKED && mode.bank1)
            ram_addr = {BANK1_PAGE, addr[PG_LO-1:0]};
        case (region)
            RG_SWITCH: ram_we = 1'b0;
            RG_LOWER:  ram_we = wr;
            default:   ram_we = wr && !mode.wprot;
        endcase
        if (region == RG_SWITCH)
            rdata = '0;
        else if (upper && mode.rd_rom)
            rdata = rom_data;
        else
            rdata = ram_rdata;
    end

    // R4
    wprot_chk: assert property (@(posedge clk) disable iff (rst)
        (upper && mode.wprot) |-> !ram_we);

    // R7
    switch_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (region == RG_SWITCH) |-> (!ram_we && rdata == '0));

    // R8
    lower_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (region == RG_LOWER) |-> (ram_addr == addr && ram_we == wr));

    // R2
    fixed_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (region == RG_FIXED) |-> (ram_addr == addr));

    // R2
    bank1_page_chk: assert property (@(posedge clk) disable iff (rst)
        (region == RG_BANKED && mode.bank1 && (rd || wr)) |-> (ram_addr[AW-1:PG_LO] == BANK1_PAGE));
endmodule

// File: rtl/lcard_mapper.sv
module lcard_mapper
    import lcard_pkg::*;
#(
    parameter int AW = LC_AW,
    parameter int DW = LC_DW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] cpu_addr,
    input  logic [DW-1:0] cpu_wdata,
    input  logic          cpu_rd,
    input  logic          cpu_wr,
    output logic [DW-1:0] cpu_rdata,
    output logic [AW-1:0] ram_addr,
    output logic [DW-1:0] ram_wdata,
    output logic          ram_we,
    input  logic [DW-1:0] ram_rdata
);
    localparam int RAW = LC_ROM_AW;
    localparam int PG_LO = AW - 4;

    lc_region_e       region;
    lc_mode_t         mode;
    logic             sw_hit;
    logic [RAW-1:0]   rom_off;
    logic [DW-1:0]    rom_data;

    lcard_region_dec #(.AW(AW)) u_dec (
        .addr   (cpu_addr),
        .region (region)
    );

    assign sw_hit = (region == RG_SWITCH) && (cpu_rd || cpu_wr);

    lcard_mode_reg u_mode (
        .clk      (clk),
        .rst      (rst),
        .hit      (sw_hit),
        .sel_bank (cpu_addr[3]),
        .sel_code (cpu_addr[1:0]),
        .mode     (mode)
    );

    // Offset into the image: page D -> 0, E -> 1, F -> 2.
    assign rom_off = {cpu_addr[PG_LO+1:PG_LO] - 2'd1, cpu_addr[PG_LO-1:0]};

    lcard_rom #(.RAW(RAW), .DW(DW)) u_rom (
        .off  (rom_off),
        .data (rom_data)
    );

    lcard_addr_map #(.AW(AW), .DW(DW)) u_map (
        .clk       (clk),
        .rst       (rst),
        .region    (region),
        .mode      (mode),
        .addr      (cpu_addr),
        .wdata     (cpu_wdata),
        .rd        (cpu_rd),
        .wr        (cpu_wr),
        .rom_data  (rom_data),
        .ram_rdata (ram_rdata),
        .ram_addr  (ram_addr),
        .ram_wdata (ram_wdata),
        .ram_we    (ram_we),
        .rdata     (cpu_rdata)
    );

    // R1
    reset_mode_chk: assert property (@(posedge clk)
        rst |=> (mode == LC_MODE_RESET));
endmodule

// File: tb/lcard_mapper_test.sv
module lcard_mapper_test;
    localparam int CLK_PERIOD = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cpu_addr = 16'h0;
    logic [7:0]  cpu_wdata = 8'h0;
    logic        cpu_rd = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [7:0]  cpu_rdata;
    logic [15:0] ram_addr;
    logic [7:0]  ram_wdata;
    logic        ram_we;
    logic [7:0]  ram_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lcard_mapper uut (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_rdata(cpu_rdata),
        .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_we(ram_we),
        .ram_rdata(ram_rdata)
    );

    // Sparse physical RAM model
    logic [7:0] mem [logic [15:0]];
    int mem_gen = 0;

    function automatic logic [7:0] peek(input logic [15:0] a);
        return mem.exists(a) ? mem[a] : 8'h00;
    endfunction

    always @(ram_addr or mem_gen) ram_rdata = peek(ram_addr);

    always @(posedge clk) begin
        if (ram_we) begin
            mem[ram_addr] = ram_wdata;
            mem_gen = mem_gen + 1;
        end
    end

    function automatic logic [7:0] img(input logic [15:0] a);
        logic [15:0] k;
        k = a - 16'hD000;
        return (k[7:0] ^ 8'h5A) ^ {2'b00, k[13:8]};
    endfunction

    typedef struct {
        bit          chk_rd;
        logic [7:0]  rd;
        logic        we;
        logic [15:0] ra;
        string       req;
    } exp_t;

    exp_t sb[$];

    task automatic bus(input bit r, input bit w, input logic [15:0] a,
                       input logic [7:0] d, input exp_t e);
        @(negedge clk);
        cpu_rd = r; cpu_wr = w; cpu_addr = a; cpu_wdata = d;
        sb.push_back(e);
    endtask

    task automatic rd_chk(input logic [15:0] a, input logic [7:0] v, input string req);
        exp_t e;
        e.chk_rd = 1'b1; e.rd = v; e.we = 1'b0; e.ra = 16'h0; e.req = req;
        bus(1'b1, 1'b0, a, 8'h00, e);
    endtask

    task automatic wr_chk(input logic [15:0] a, input logic [7:0] d,
                          input logic we, input logic [15:0] ra, input string req);
        exp_t e;
        e.chk_rd = 1'b0; e.rd = 8'h0; e.we = we; e.ra = ra; e.req = req;
        bus(1'b0, 1'b1, a, d, e);
    endtask

    task automatic sw_chk(input bit as_read, input logic [15:0] a, input string req);
        exp_t e;
        e.chk_rd = as_read; e.rd = 8'h00; e.we = 1'b0; e.ra = 16'h0; e.req = req;
        bus(as_read, !as_read, a, 8'hA7, e);
    endtask

    task automatic idle();
        @(negedge clk);
        cpu_rd = 1'b0; cpu_wr = 1'b0;
    endtask

    task automatic mem_chk(input logic [15:0] a, input logic [7:0] v, input string req);
        idle();
        idle();
        checks++;
        if (peek(a) !== v) begin
            errors++;
            $display("FAIL %s: ram[%h] actual=%h expected=%h", req, a, peek(a), v);
        end
    endtask

    // Monitor: compare design outputs against queued expectations
    initial begin
        forever begin
            @(negedge clk);
            #(CLK_PERIOD/4);
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                if (e.chk_rd) begin
                    checks++;
                    if (cpu_rdata !== e.rd) begin
                        errors++;
                        $display("FAIL %s: rdata actual=%h expected=%h (addr %h)", e.req, cpu_rdata, e.rd, cpu_addr);
                    end
                end
                checks++;
                if (ram_we !== e.we) begin
                    errors++;
                    $display("FAIL %s: ram_we actual=%b expected=%b (addr %h)", e.req, ram_we, e.we, cpu_addr);
                end
                if (e.we) begin
                    checks++;
                    if (ram_addr !== e.ra) begin
                        errors++;
                        $display("FAIL %s: ram_addr actual=%h expected=%h", e.req, ram_addr, e.ra);
                    end
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 R11: image reads after reset
        rd_chk(16'hFFFF, img(16'hFFFF), "R1");
        rd_chk(16'hE123, img(16'hE123), "R11");
        // R1 R3: writes go through while image is read
        wr_chk(16'hD000, 8'hFE, 1'b1, 16'hD000, "R3");
        wr_chk(16'hFFFF, 8'hFF, 1'b1, 16'hFFFF, "R3");
        rd_chk(16'hD000, img(16'hD000), "R3");
        rd_chk(16'hFFFF, img(16'hFFFF), "R3");
        // R8: lower pass-through
        wr_chk(16'h0123, 8'h77, 1'b1, 16'h0123, "R8");
        rd_chk(16'h0123, 8'h77, "R8");

        // R7 R9: control read, then bank 1 write in the very next cycle
        sw_chk(1'b1, 16'hC08B, "R7");
        wr_chk(16'hD000, 8'hFD, 1'b1, 16'hC000, "R9");
        rd_chk(16'hD000, 8'hFD, "R10");
        mem_chk(16'hD000, 8'hFE, "R2");
        mem_chk(16'hC000, 8'hFD, "R2");

        // R7: control write, bank 2 RAM reads
        sw_chk(1'b0, 16'hC083, "R7");
        rd_chk(16'hD000, 8'hFE, "R10");
        rd_chk(16'hFFFF, 8'hFF, "R6");

        // R4 R6: bank 1, RAM read, protected
        sw_chk(1'b1, 16'hC088, "R6");
        wr_chk(16'hD000, 8'h01, 1'b0, 16'h0, "R4");
        wr_chk(16'hFFFF, 8'h02, 1'b0, 16'h0, "R4");
        rd_chk(16'hD000, 8'hFD, "R4");
        rd_chk(16'hFFFF, 8'hFF, "R4");
        wr_chk(16'h0200, 8'h33, 1'b1, 16'h0200, "R8");
        mem_chk(16'hD000, 8'hFE, "R4");

        // R5 R6: bit 2 set, code 10 (image, protected), bank 1
        sw_chk(1'b1, 16'hC08E, "R5");
        rd_chk(16'hD000, img(16'hD000), "R6");
        wr_chk(16'hE000, 8'h99, 1'b0, 16'h0, "R6");

        // R5: bit 2 set, code 01, bank 2, writes allowed
        sw_chk(1'b0, 16'hC085, "R5");
        wr_chk(16'hD010, 8'h44, 1'b1, 16'hD010, "R5");
        rd_chk(16'hD010, img(16'hD010), "R3");

        // R10: bank 1 RAM read-write
        sw_chk(1'b1, 16'hC08F, "R10");
        rd_chk(16'hD010, 8'h00, "R10");
        rd_chk(16'hD000, 8'hFD, "R10");
        wr_chk(16'hD000, 8'hFC, 1'b1, 16'hC000, "R2");
        wr_chk(16'hE800, 8'h5B, 1'b1, 16'hE800, "R2");
        rd_chk(16'hE800, 8'h5B, "R2");
        mem_chk(16'hC000, 8'hFC, "R2");
        mem_chk(16'hD010, 8'h44, "R5");

        // R1: reset in the middle restores the image and bank 2
        idle();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        rd_chk(16'hD000, img(16'hD000), "R1");
        wr_chk(16'hD020, 8'h12, 1'b1, 16'hD020, "R1");
        idle();
        idle();

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule